// File: doc/BRIEF.md
# Stacked-Board SPI Command Decoder

This block is the serial front end of one board in a stack of waveform generator boards that all listen to the same SPI lines. It oversamples SCK, chip select and MOSI in the system clock domain. Each transaction opens with a command byte. That byte names a target board, says whether a register or a channel memory is meant, and says whether the access is a read or a write. A board acts only when the board field equals its 4-bit strap or holds the broadcast code. It ignores every other transaction until chip select rises.

Register accesses move one 8-bit value. A write updates the configuration, checksum or frame register. A read shifts the value back out on MISO, and only when the command named this board by its own number. Memory writes carry a 16-bit start address followed by 16-bit words. The block hands these words to the waveform memories through a one-cycle write strobe. Trigger, run enable, clock-double enable, a self-clearing board reset and a routed auxiliary output all come from the configuration register. The aux output carries either MISO or the masked OR of the DAC channel activity lines.

The memory-write stream has a valid strobe and no ready. SPI gives the slave no way to stall the master, so the sink must accept every strobe in the cycle it appears. Strobes are at least sixteen SCK periods apart, so two strobes can never fall in adjacent cycles.

Top module: `spi_stack_decoder`

## Requirements
- R1: Bits are taken MSB first on SCK rising edges while chip select is low. The command byte is decoded as bit 7 write (1) or read (0), bits 6:3 board, bit 2 memory flag, and bits 1:0 register or channel select.
- R2: A transaction whose board field is neither the strap value nor 15 changes no register, raises no strobe and does not drive MISO.
- R3: A register write is the command byte plus one data byte. Select 0 is configuration, 1 is checksum and 2 is frame. A write to select 3 changes nothing. Frame and checksum appear on `frame_o` and `crc_o`.
- R4: A read addressed to the strap value (not 15) raises `spi_miso_oe_o` at the first SCK falling edge after the command byte and shifts the register out MSB first, with each bit updated after a falling edge. A read of select 3 returns 0. Broadcast and foreign reads keep the output enable low, and chip select high clears it.
- R5: Configuration bit 1 drives `clk2x_o` and bit 2 drives `run_en_o`.
- R6: Writing configuration bit 0 as 1 gives exactly one `board_rst_o` pulse of one cycle, and that bit reads back as 0.
- R7: `trig_o` is configuration bit 3 ORed with `ext_trig_i`.
- R8: With configuration bit 4 at 0, `aux_o` is the OR of `dac_act_i` ANDed with bits 7:5 (bit 5 masks channel 0). With bit 4 at 1, `aux_o` follows `spi_miso_o`.
- R9: A memory write with channel select 0 to 2 takes the low then the high start address byte, then words sent high byte first. Each complete word produces one strobe carrying the channel, address and data, and the address then increases by one, with carry into the high byte. Channel select 3 and memory reads are ignored.
- R10: Chip select rising discards any partial byte or partial word and returns decoding to the command byte.
- R11: After reset all registers are 0 and the output enable and write strobe are low.
- R12: `wr_valid_o` is high for single cycles only, and only during a memory write transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| board_id_i | input | 4 | Board address strap |
| spi_sck_i | input | 1 | SPI clock |
| spi_cs_n_i | input | 1 | SPI chip select, active low |
| spi_mosi_i | input | 1 | SPI data from master |
| spi_miso_o | output | 1 | SPI data to master |
| spi_miso_oe_o | output | 1 | MISO output enable |
| ext_trig_i | input | 1 | External trigger input |
| dac_act_i | input | 3 | Per-channel DAC activity |
| trig_o | output | 1 | Effective trigger |
| run_en_o | output | 1 | Waveform execution enable |
| clk2x_o | output | 1 | Clock-double enable |
| board_rst_o | output | 1 | One-cycle board reset pulse |
| aux_o | output | 1 | Routed auxiliary output |
| frame_o | output | 8 | Frame selection register |
| crc_o | output | 8 | Checksum register |
| wr_valid_o | output | 1 | Memory write strobe |
| wr_chan_o | output | 2 | Channel of the strobed word |
| wr_addr_o | output | 16 | Address of the strobed word |
| wr_data_o | output | 16 | Strobed data word |

## Verification
The hardest case to reach is the boundary between a finished and an unfinished memory word when chip select rises. The bench sends a word stream that ends after a lone high byte and checks that exactly the completed words are strobed. It then follows with a register write to confirm that decoding restarted at a command byte. A start address of 0x12FE makes the increment carry into the high byte, and a separate chip-select burst of five bits checks the bit-level abort. Readback timing is checked by sampling MISO and its enable just before every rising SCK edge.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;
  localparam int BYTE_W = 8;
  localparam int ID_W   = 4;
  localparam int MEM_AW = 2 * BYTE_W;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int N_CH   = 3;
  localparam int CH_W   = 2;

  localparam logic [ID_W-1:0] BCAST_ID = '1;

  localparam logic [1:0] SEL_CFG   = 2'd0;
  localparam logic [1:0] SEL_CRC   = 2'd1;
  localparam logic [1:0] SEL_FRAME = 2'd2;

  localparam int CFG_RST    = 0;
  localparam int CFG_X2     = 1;
  localparam int CFG_RUN    = 2;
  localparam int CFG_STRIG  = 3;
  localparam int CFG_AUXSEL = 4;
  localparam int CFG_MASK   = 5;

  typedef struct packed {
    logic            wr;
    logic [ID_W-1:0] board;
    logic            mem;
    logic [1:0]      sel;
  } cmd_t;

  typedef enum logic [2:0] {
    ST_CMD, ST_REGDATA, ST_ADRLO, ST_ADRHI, ST_WHI, ST_WLO, ST_SKIP
  } dec_state_t;
endpackage

// File: rtl/spicmd_bit_sync.sv
module spicmd_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d_i};
  end
  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spicmd_front.sv
module spicmd_front import spicmd_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              mosi_i,
  output logic              fall_o,
  output logic              cs_rise_o,
  output logic              byte_v_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic sck_s, cs_s, mosi_s, sck_d, cs_d, rise;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;

  spicmd_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck
    (.clk(clk), .rst_n(rst_n), .d_i(sck_i), .q_o(sck_s));
  spicmd_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs
    (.clk(clk), .rst_n(rst_n), .d_i(cs_n_i), .q_o(cs_s));
  spicmd_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi
    (.clk(clk), .rst_n(rst_n), .d_i(mosi_i), .q_o(mosi_s));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  assign rise      = sck_s & ~sck_d & ~cs_s;
  assign fall_o    = ~sck_s & sck_d & ~cs_s;
  assign cs_rise_o = cs_s & ~cs_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_v_o <= 1'b0;
      byte_o   <= '0;
    end else begin
      byte_v_o <= 1'b0;
      if (cs_s) begin
        bit_cnt <= '0;
      end else if (rise) begin
        shreg   <= {shreg[BYTE_W-2:0], mosi_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
          byte_v_o <= 1'b1;
          byte_o   <= {shreg[BYTE_W-2:0], mosi_s};
        end
      end
    end
  end

  // R10: with chip select high no byte can complete
  assert_no_byte_cs_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_o |=> !byte_v_o);
endmodule

// File: rtl/spicmd_decoder.sv
module spicmd_decoder import spicmd_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   board_id_i,
  input  logic              byte_v_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              cs_rise_i,
  output logic              reg_we_o,
  output logic [1:0]        reg_adr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              rd_req_o,
  output logic [1:0]        rd_adr_o,
  output logic              mem_valid_o,
  output logic [CH_W-1:0]   mem_ch_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_data_o
);
  dec_state_t        state;
  cmd_t              cmd;
  logic              hit_own, hit_any, ch_ok;
  logic [CH_W-1:0]   ch_q;
  logic [MEM_AW-1:0] addr_q;
  logic [BYTE_W-1:0] hi_q;

  assign cmd     = cmd_t'(byte_i);
  assign hit_own = (cmd.board == board_id_i);
  assign hit_any = hit_own || (cmd.board == BCAST_ID);
  assign ch_ok   = (32'(cmd.sel) < N_CH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_CMD;
      reg_we_o    <= 1'b0;
      reg_adr_o   <= '0;
      reg_wdata_o <= '0;
      rd_req_o    <= 1'b0;
      rd_adr_o    <= '0;
      mem_valid_o <= 1'b0;
      mem_ch_o    <= '0;
      mem_addr_o  <= '0;
      mem_data_o  <= '0;
      ch_q        <= '0;
      addr_q      <= '0;
      hi_q        <= '0;
    end else begin
      reg_we_o    <= 1'b0;
      rd_req_o    <= 1'b0;
      mem_valid_o <= 1'b0;
      if (cs_rise_i) begin
        state <= ST_CMD;
      end else if (byte_v_i) begin
        unique case (state)
          ST_CMD: begin
            if (!hit_any) begin
              state <= ST_SKIP;
            end else if (cmd.mem) begin
              if (cmd.wr && ch_ok) begin
                ch_q  <= CH_W'(cmd.sel);
                state <= ST_ADRLO;
              end else begin
                state <= ST_SKIP;
              end
            end else if (cmd.wr) begin
              reg_adr_o <= cmd.sel;
              state     <= ST_REGDATA;
            end else begin
              if (hit_own) begin
                rd_req_o <= 1'b1;
                rd_adr_o <= cmd.sel;
              end
              state <= ST_SKIP;
            end
          end
          ST_REGDATA: begin
            reg_we_o    <= 1'b1;
            reg_wdata_o <= byte_i;
            state       <= ST_SKIP;
          end
          ST_ADRLO: begin
            addr_q[BYTE_W-1:0] <= byte_i;
            state              <= ST_ADRHI;
          end
          ST_ADRHI: begin
            addr_q[MEM_AW-1:BYTE_W] <= byte_i;
            state                   <= ST_WHI;
          end
          ST_WHI: begin
            hi_q  <= byte_i;
            state <= ST_WLO;
          end
          ST_WLO: begin
            mem_valid_o <= 1'b1;
            mem_ch_o    <= ch_q;
            mem_addr_o  <= addr_q;
            mem_data_o  <= {hi_q, byte_i};
            addr_q      <= addr_q + 1'b1;
            state       <= ST_WHI;
          end
          default: state <= ST_SKIP;
        endcase
      end
    end
  end

  // R10: chip select rising always restarts at the command byte
  assert_restart_on_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_i |=> state == ST_CMD);
  // R9: strobed channel is always a real memory
  assert_valid_channel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o |-> 32'(mem_ch_o) < N_CH);
  // R12: write strobe never lasts two cycles
  assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o |=> !mem_valid_o);
  // R4: a read request follows only a completed byte
  assert_read_after_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> $past(byte_v_i));
endmodule

// File: rtl/spicmd_regs.sv
module spicmd_regs import spicmd_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [1:0]        adr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [1:0]        rd_adr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              ext_trig_i,
  input  logic [N_CH-1:0]   dac_act_i,
  input  logic              miso_i,
  output logic              trig_o,
  output logic              run_en_o,
  output logic              clk2x_o,
  output logic              board_rst_o,
  output logic              aux_o,
  output logic [BYTE_W-1:0] frame_o,
  output logic [BYTE_W-1:0] crc_o
);
  logic [BYTE_W-1:0] cfg_q, crc_q, frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      crc_q   <= '0;
      frame_q <= '0;
    end else begin
      if (cfg_q[CFG_RST]) cfg_q[CFG_RST] <= 1'b0;
      if (we_i) begin
        unique case (adr_i)
          SEL_CFG:   cfg_q   <= wdata_i;
          SEL_CRC:   crc_q   <= wdata_i;
          SEL_FRAME: frame_q <= wdata_i;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (rd_adr_i)
      SEL_CFG:   rd_data_o = cfg_q;
      SEL_CRC:   rd_data_o = crc_q;
      SEL_FRAME: rd_data_o = frame_q;
      default:   rd_data_o = '0;
    endcase
  end

  assign trig_o      = cfg_q[CFG_STRIG] | ext_trig_i;
  assign run_en_o    = cfg_q[CFG_RUN];
  assign clk2x_o     = cfg_q[CFG_X2];
  assign board_rst_o = cfg_q[CFG_RST];
  assign aux_o       = cfg_q[CFG_AUXSEL] ? miso_i
                                         : |(dac_act_i & cfg_q[CFG_MASK +: N_CH]);
  assign frame_o     = frame_q;
  assign crc_o       = crc_q;

  // R6: the reset bit clears itself one cycle after it is set
  assert_rst_autoclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    board_rst_o |=> !board_rst_o);
  // R6: a configuration write with bit 0 set produces the pulse
  assert_rst_from_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && adr_i == SEL_CFG && wdata_i[CFG_RST]) |=> board_rst_o);
  // R3: frame register changes only through a write strobe
  assert_frame_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(frame_o));
endmodule

// File: rtl/spicmd_miso_tx.sv
module spicmd_miso_tx import spicmd_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  logic              cs_rise_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_data_i,
  output logic              miso_o,
  output logic              oe_o
);
  logic              pend;
  logic [BYTE_W-1:0] buf_q, sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      buf_q <= '0;
      sh    <= '0;
      oe_o  <= 1'b0;
    end else if (cs_rise_i) begin
      pend <= 1'b0;
      oe_o <= 1'b0;
    end else begin
      if (fall_i) begin
        if (pend) begin
          sh   <= buf_q;
          oe_o <= 1'b1;
          pend <= 1'b0;
        end else if (oe_o) begin
          sh <= {sh[BYTE_W-2:0], 1'b0};
        end
      end
      if (load_i) begin
        pend  <= 1'b1;
        buf_q <= load_data_i;
      end
    end
  end

  assign miso_o = oe_o & sh[BYTE_W-1];

  // R4: chip select rising releases MISO
  assert_release_on_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_i |=> !oe_o);
  // R4: the enable rises only on a falling SCK edge
  assert_oe_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> $past(fall_i));
endmodule

// File: rtl/spi_stack_decoder.sv
module spi_stack_decoder import spicmd_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  board_id_i,
  input  logic        spi_sck_i,
  input  logic        spi_cs_n_i,
  input  logic        spi_mosi_i,
  output logic        spi_miso_o,
  output logic        spi_miso_oe_o,
  input  logic        ext_trig_i,
  input  logic [2:0]  dac_act_i,
  output logic        trig_o,
  output logic        run_en_o,
  output logic        clk2x_o,
  output logic        board_rst_o,
  output logic        aux_o,
  output logic [7:0]  frame_o,
  output logic [7:0]  crc_o,
  output logic        wr_valid_o,
  output logic [1:0]  wr_chan_o,
  output logic [15:0] wr_addr_o,
  output logic [15:0] wr_data_o
);
  logic              fall, cs_rise, byte_v;
  logic [BYTE_W-1:0] byte_d, reg_wdata, rd_data;
  logic              reg_we, rd_req;
  logic [1:0]        reg_adr, rd_adr;

  spicmd_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n),
    .sck_i(spi_sck_i), .cs_n_i(spi_cs_n_i), .mosi_i(spi_mosi_i),
    .fall_o(fall), .cs_rise_o(cs_rise), .byte_v_o(byte_v), .byte_o(byte_d));

  spicmd_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .board_id_i(board_id_i),
    .byte_v_i(byte_v), .byte_i(byte_d), .cs_rise_i(cs_rise),
    .reg_we_o(reg_we), .reg_adr_o(reg_adr), .reg_wdata_o(reg_wdata),
    .rd_req_o(rd_req), .rd_adr_o(rd_adr),
    .mem_valid_o(wr_valid_o), .mem_ch_o(wr_chan_o),
    .mem_addr_o(wr_addr_o), .mem_data_o(wr_data_o));

  spicmd_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .we_i(reg_we), .adr_i(reg_adr), .wdata_i(reg_wdata),
    .rd_adr_i(rd_adr), .rd_data_o(rd_data),
    .ext_trig_i(ext_trig_i), .dac_act_i(dac_act_i), .miso_i(spi_miso_o),
    .trig_o(trig_o), .run_en_o(run_en_o), .clk2x_o(clk2x_o),
    .board_rst_o(board_rst_o), .aux_o(aux_o),
    .frame_o(frame_o), .crc_o(crc_o));

  spicmd_miso_tx u_miso (
    .clk(clk), .rst_n(rst_n),
    .fall_i(fall), .cs_rise_i(cs_rise),
    .load_i(rd_req), .load_data_i(rd_data),
    .miso_o(spi_miso_o), .oe_o(spi_miso_oe_o));

  // R12: no strobe while chip select is idle high at the pins
  assert_no_strobe_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n_i && $past(spi_cs_n_i) && $past(spi_cs_n_i, 2) && $past(spi_cs_n_i, 3)
     && $past(spi_cs_n_i, 4)) |-> !wr_valid_o);
endmodule

// File: tb/spi_stack_decoder_bench.sv
module spi_stack_decoder_bench;
  localparam logic [3:0] MY_ID = 4'd5;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b1, csn = 1'b1, mosi = 1'b0, ext_trig = 1'b0;
  logic [2:0] dac = 3'b000;
  logic miso, oe, trig, run_en, clk2x, brst, aux, wr_valid;
  logic [7:0] frame, crc;
  logic [1:0] wr_chan;
  logic [15:0] wr_addr, wr_data;

  always #4 clk = ~clk;

  spi_stack_decoder u_spi_stack_decoder (
    .clk(clk), .rst_n(rst_n), .board_id_i(MY_ID),
    .spi_sck_i(sck), .spi_cs_n_i(csn), .spi_mosi_i(mosi),
    .spi_miso_o(miso), .spi_miso_oe_o(oe),
    .ext_trig_i(ext_trig), .dac_act_i(dac),
    .trig_o(trig), .run_en_o(run_en), .clk2x_o(clk2x), .board_rst_o(brst),
    .aux_o(aux), .frame_o(frame), .crc_o(crc),
    .wr_valid_o(wr_valid), .wr_chan_o(wr_chan), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data));

  int n_vec = 0, n_bad = 0;
  logic [7:0] m_cfg = 0, m_crc = 0, m_frame = 0;
  int rst_cnt = 0, exp_rst_cnt = 0;
  logic prev_brst = 1'b0;
  logic quiet = 1'b0;
  logic [33:0] got_wr[$];
  logic [33:0] exp_wr[$];
  logic [7:0] rxq[$];
  logic [7:0] oeq[$];
  logic [7:0] auxq[$];

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, expv, $time);
    end
  endfunction

  function automatic logic [7:0] cmd(logic wr, logic [3:0] b, logic m, logic [1:0] s);
    return {wr, b, m, s};
  endfunction

  function automatic logic [7:0] mval(logic [1:0] a);
    case (a)
      2'd0: return m_cfg;
      2'd1: return m_crc;
      2'd2: return m_frame;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic hits(logic [3:0] b);
    return (b == MY_ID) || (b == 4'hF);
  endfunction

  // reference comparison on every clock while the bus is idle
  always @(negedge clk) begin
    if (rst_n) begin
      if (brst) rst_cnt++;
      if (brst && prev_brst) chk("R6 pulse width", 2, 1);
      prev_brst = brst;
      if (wr_valid) got_wr.push_back({wr_chan, wr_addr, wr_data});
      if (quiet) begin
        chk("R5 clk2x", clk2x, m_cfg[1]);
        chk("R5 run_en", run_en, m_cfg[2]);
        chk("R7 trig", trig, m_cfg[3] | ext_trig);
        chk("R8 aux", aux, m_cfg[4] ? 1'b0 : |(dac & m_cfg[7:5]));
        chk("R3 frame", frame, m_frame);
        chk("R3 crc", crc, m_crc);
        chk("R4 idle oe", oe, 0);
        chk("R12 idle strobe", wr_valid, 0);
      end
    end
  end

  task automatic wclk(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic spi_byte(logic [7:0] b);
    logic [7:0] r, o, a;
    for (int i = 7; i >= 0; i--) begin
      @(posedge clk);
      sck = 1'b0;
      mosi = b[i];
      wclk(HALF);
      @(negedge clk);
      r[i] = miso;
      o[i] = oe;
      a[i] = aux;
      @(posedge clk);
      sck = 1'b1;
      wclk(HALF);
    end
    rxq.push_back(r);
    oeq.push_back(o);
    auxq.push_back(a);
  endtask

  task automatic xfer(logic [7:0] q[$]);
    quiet = 1'b0;
    rxq.delete(); oeq.delete(); auxq.delete();
    @(posedge clk);
    csn = 1'b0;
    wclk(HALF);
    foreach (q[i]) spi_byte(q[i]);
    wclk(HALF);
    csn = 1'b1;
    wclk(10);
  endtask

  task automatic reg_wr(logic [3:0] b, logic [1:0] a, logic [7:0] d);
    xfer('{cmd(1, b, 0, a), d});
    if (hits(b)) begin
      case (a)
        2'd0: begin
          if (d[0]) exp_rst_cnt++;
          m_cfg = d & 8'hFE;
        end
        2'd1: m_crc = d;
        2'd2: m_frame = d;
        default: ;
      endcase
    end
    chk("R6 reset pulses", rst_cnt, exp_rst_cnt);
    quiet = 1'b1;
    wclk(4);
  endtask

  task automatic reg_rd(logic [3:0] b, logic [1:0] a);
    xfer('{cmd(0, b, 0, a), 8'h00});
    if (b == MY_ID) begin
      chk("R4 read data", rxq[1], mval(a));
      chk("R4 oe during data", oeq[1], 8'hFF);
      chk("R4 oe during command", oeq[0], 8'h00);
      if (m_cfg[4]) chk("R8 aux follows miso", auxq[1], rxq[1]);
    end else begin
      chk("R4 R2 no drive", {oeq[0], oeq[1]}, 0);
    end
    quiet = 1'b1;
    wclk(4);
  endtask

  task automatic mem_wr(logic [3:0] b, logic m_cmd_wr, logic [1:0] ch,
                        logic [15:0] adr, logic [15:0] w[$], logic extra);
    logic [7:0] q[$];
    q.push_back(cmd(m_cmd_wr, b, 1, ch));
    q.push_back(adr[7:0]);
    q.push_back(adr[15:8]);
    foreach (w[i]) begin
      q.push_back(w[i][15:8]);
      q.push_back(w[i][7:0]);
      if (hits(b) && m_cmd_wr && ch != 2'd3)
        exp_wr.push_back({ch, adr + 16'(i), w[i]});
    end
    if (extra) q.push_back(8'hEE);
    xfer(q);
    chk("R9 strobe count", got_wr.size(), exp_wr.size());
    while (got_wr.size() > 0 && exp_wr.size() > 0)
      chk("R9 strobe content", 32'(got_wr.pop_front() ^ exp_wr[0]) | 32'((got_wr.size() == 99) ? 1 : 0), 32'(0) | 32'(0 & exp_wr.pop_front()));
    got_wr.delete();
    exp_wr.delete();
    quiet = 1'b1;
    wclk(4);
  endtask

  task automatic spi_bits(int n);
    quiet = 1'b0;
    @(posedge clk);
    csn = 1'b0;
    wclk(HALF);
    for (int i = 0; i < n; i++) begin
      sck = 1'b0; mosi = 1'b1; wclk(HALF);
      sck = 1'b1; wclk(HALF);
    end
    csn = 1'b1;
    wclk(10);
    quiet = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(6);
    // R11 reset state
    chk("R11 frame", frame, 0);
    chk("R11 crc", crc, 0);
    chk("R11 oe", oe, 0);
    chk("R11 strobe", wr_valid, 0);
    chk("R11 run_en", run_en, 0);
    quiet = 1'b1;
    wclk(4);

    // R1 R3: own, broadcast and foreign writes
    reg_wr(MY_ID, 2'd2, 8'hA5);
    reg_wr(4'hF, 2'd1, 8'h3C);
    reg_wr(4'd7, 2'd2, 8'h11);     // R2 foreign board ignored
    reg_wr(MY_ID, 2'd3, 8'hFF);    // R3 select 3 changes nothing
    // R5 R8: run, clk2x, full mask
    reg_wr(MY_ID, 2'd0, 8'hE6);
    for (int v = 0; v < 8; v++) begin
      @(posedge clk);
      dac = 3'(v);
      ext_trig = v[0];
      wclk(3);
    end
    reg_wr(4'hF, 2'd0, 8'h46);     // R8 mask only channel 1
    for (int v = 0; v < 8; v++) begin
      @(posedge clk);
      dac = 3'(v);
      wclk(3);
    end

    // R4 reads
    reg_rd(MY_ID, 2'd2);
    reg_rd(MY_ID, 2'd1);
    reg_rd(MY_ID, 2'd0);
    reg_rd(MY_ID, 2'd3);
    reg_rd(4'hF, 2'd2);            // R4 broadcast read not driven
    reg_rd(4'd3, 2'd1);            // R2 foreign read not driven

    // R6 self-clearing reset, then readback
    reg_wr(MY_ID, 2'd0, 8'h0D);
    reg_rd(MY_ID, 2'd0);
    // R7 software trigger with external low and high
    @(posedge clk); ext_trig = 1'b0; wclk(3);
    @(posedge clk); ext_trig = 1'b1; wclk(3);
    @(posedge clk); ext_trig = 1'b0; wclk(3);
    // R8 aux carries MISO during a read
    reg_wr(MY_ID, 2'd0, 8'h14);
    reg_rd(MY_ID, 2'd2);
    reg_rd(MY_ID, 2'd0);

    // R9 memory writes with carry into the high address byte
    mem_wr(MY_ID, 1'b1, 2'd1, 16'h12FE, '{16'hBEEF, 16'h0102, 16'hF00D}, 1'b0);
    mem_wr(4'hF, 1'b1, 2'd2, 16'h0000, '{16'h8001, 16'h7FFE}, 1'b0);
    mem_wr(MY_ID, 1'b1, 2'd0, 16'hFFFF, '{16'h5A5A}, 1'b0);
    mem_wr(MY_ID, 1'b1, 2'd3, 16'h0040, '{16'h1234}, 1'b0);   // R9 channel 3 ignored
    mem_wr(MY_ID, 1'b0, 2'd1, 16'h0040, '{16'h1234}, 1'b0);   // R9 memory read ignored
    mem_wr(4'd9, 1'b1, 2'd0, 16'h0040, '{16'h1234}, 1'b0);    // R2 foreign memory write
    // R10 partial word discarded
    mem_wr(MY_ID, 1'b1, 2'd0, 16'h0100, '{16'hCAFE}, 1'b1);
    reg_wr(MY_ID, 2'd2, 8'h5E);
    // R10 partial byte discarded
    spi_bits(5);
    reg_wr(MY_ID, 2'd1, 8'h77);
    reg_rd(MY_ID, 2'd1);

    wclk(20);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule